// File: doc/BRIEF.md
# SD Card Short-Response Status Decoder

This block turns one captured 48-bit short response from an SD card into a small set of decoded results. The response arrives as a packed vector, byte 0 in the top eight bits. With it come the index of the command that was issued, a flag that marks the response as a published-address response, and two upstream fault flags from the receiver. The block produces one prioritized error code, the card's 4-bit current-state field, the ready-for-data flag and, for address responses, the card address already placed where a command argument needs it.

A one-cycle `in_strobe` loads the inputs. The decoded results are registered and appear one clock later, qualified by a one-cycle `out_valid` pulse. Between strobes the results hold their last value. The control is a two-state machine. `ST_IDLE` moves to `ST_SHOW` on a strobe (transition *capture*). `ST_SHOW` stays in `ST_SHOW` on a further strobe (*recapture*) and returns to `ST_IDLE` without one (*release*). `ST_IDLE` without a strobe stays put (*wait*).

Many status bits collapse into a single code through a fixed priority chain. The card-locked bit is deliberately left out of that chain. A mismatch between the echoed command index and the issued one is reported only when no status error is present, because it is the least severe outcome.

Top module: `rsp_status_decode`

## Requirements
- R1: One clock edge after an edge with `in_strobe` high, `out_valid` is high for exactly that cycle. After an edge with `in_strobe` low, `out_valid` is low and `err_code`, `card_state`, `rdy_data` and `rca_arg` keep their previous values.
- R2: Byte 0 is `rsp_bytes[47:40]`. The 32-bit status word is bytes 1 to 4 (`rsp_bytes[39:8]`), most significant byte first. `card_state` is status bits 12:9 and `rdy_data` is status bit 8.
- R3: When any status bit in 31:13 is set, the highest-priority set bit gives the code. The codes are: bit 31 → 3, bit 30 → 4, bit 29 → 5, bit 28 → 6, bit 27 → 7, bit 26 → 8, bit 24 → 9, bit 23 → 10, bit 22 → 11, bit 21 → 12, bit 20 → 13, bit 19 → 14, bit 18 → 15, bit 17 → 16, bit 16 → 17. A higher bit number has higher priority.
- R4: Status bit 25 (card locked) never produces an error code. With only that bit set and a matching header, `err_code` is 0.
- R5: Status bits 15:13 and 12:0 produce no status error code. With only those bits set and a matching header, `err_code` is 0.
- R6: If no status error code applies and byte 0 differs from `{2'b00, issued_cmd}`, `err_code` is 18 (header mismatch). A status error code takes precedence over a header mismatch.
- R7: With `is_r6` high, `rca_arg` is `{byte1, byte2, 16'h0000}` and the status word used is `{16'h0000, byte3, byte4}`. With `is_r6` low, `rca_arg` is 0.
- R8: If `upstream_err[0]` (timeout) is set, `err_code` is 1. Otherwise, if `upstream_err[1]` (CRC) is set, `err_code` is 2. In both cases decoding is skipped and `card_state`, `rdy_data` and `rca_arg` are 0.
- R9: After reset, `out_valid`, `err_code`, `card_state`, `rdy_data` and `rca_arg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_strobe | input | 1 | Load the response inputs this edge |
| rsp_bytes | input | 48 | Captured response, byte 0 in bits 47:40 |
| issued_cmd | input | 6 | Index of the command that was sent |
| is_r6 | input | 1 | Response carries a published card address |
| upstream_err | input | 2 | Bit 0 timeout, bit 1 CRC fault from the receiver |
| out_valid | output | 1 | One-cycle pulse qualifying the results |
| err_code | output | 5 | Prioritized result code, 0 = no error |
| card_state | output | 4 | Card current-state field |
| rdy_data | output | 1 | Card ready-for-data flag |
| rca_arg | output | 32 | Card address shifted into argument position |

## Verification
The hardest case to reach is a set of status bits that enables error checking but matches no entry in the chain. Bits 15:13 and the locked bit 25 do this. The outcome then depends only on the header compare, so a wrong mask or a missing skip shows up only there. The bench drives these bits alone and again with a corrupted byte 0, expecting 0 and 18. It also drives an address response whose upper bytes have bit 31 set, which must not raise an error. Back-to-back strobes cover the *recapture* transition, and an unstrobed input change covers the hold.

// File: rtl/rsp_dec_pkg.sv
package rsp_dec_pkg;

    localparam int RSP_W    = 48;
    localparam int STAT_W   = 32;
    localparam int CODE_W   = 5;
    localparam int CHAIN_HI = 31;
    localparam int CHAIN_LO = 16;
    localparam int LOCK_BIT = 25;
    localparam int CHECK_LO = 13;

    typedef enum logic [CODE_W-1:0] {
        E_NONE     = 5'd0,
        E_TIMEOUT  = 5'd1,
        E_CRC      = 5'd2,
        E_RANGE    = 5'd3,
        E_ADDR     = 5'd4,
        E_BLKLEN   = 5'd5,
        E_ERASESEQ = 5'd6,
        E_ERASEPRM = 5'd7,
        E_WPROT    = 5'd8,
        E_LOCKFAIL = 5'd9,
        E_CMDCRC   = 5'd10,
        E_ILLEGAL  = 5'd11,
        E_ECC      = 5'd12,
        E_CTRL     = 5'd13,
        E_GENERAL  = 5'd14,
        E_UNDERRUN = 5'd15,
        E_OVERRUN  = 5'd16,
        E_REGOVWR  = 5'd17,
        E_HEADER   = 5'd18
    } err_code_t;

    // Code of a chain bit: counted down from the top, the locked bit leaves a gap
    function automatic err_code_t chain_code(input int bitpos);
        int idx;
        idx = CHAIN_HI - bitpos;
        if (bitpos < LOCK_BIT) idx = idx - 1;
        return err_code_t'(int'(E_RANGE) + idx);
    endfunction

endpackage

// File: rtl/rsp_field_split.sv
module rsp_field_split
    import rsp_dec_pkg::*;
(
    input  logic [RSP_W-1:0]  rsp,
    input  logic              addr_mode,
    output logic [STAT_W-1:0] status,
    output logic [7:0]        hdr_byte,
    output logic [31:0]       rca_word
);
    logic [7:0] b1, b2, b3, b4;

    assign hdr_byte = rsp[47:40];
    assign b1       = rsp[39:32];
    assign b2       = rsp[31:24];
    assign b3       = rsp[23:16];
    assign b4       = rsp[15:8];

    always_comb begin
        if (addr_mode) begin
            status   = {16'h0000, b3, b4};
            rca_word = {b1, b2, 16'h0000};
        end else begin
            status   = {b1, b2, b3, b4};
            rca_word = 32'h0000_0000;
        end
    end
endmodule

// File: rtl/rsp_err_chain.sv
module rsp_err_chain
    import rsp_dec_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  logic              hdr_ok,
    output err_code_t         code
);
    logic [CHAIN_HI:CHAIN_LO] hit;
    logic                     check_en;
    err_code_t                chain_res;

    genvar g;
    generate
        for (g = CHAIN_LO; g <= CHAIN_HI; g++) begin : g_hit
            if (g == LOCK_BIT) begin : g_skip
                assign hit[g] = 1'b0;
            end else begin : g_take
                assign hit[g] = status[g];
            end
        end
    endgenerate

    assign check_en = |status[STAT_W-1:CHECK_LO];

    // Lowest priority first, so the highest set bit is the last to assign
    always_comb begin
        chain_res = E_NONE;
        for (int b = CHAIN_LO; b <= CHAIN_HI; b++) begin
            if (hit[b]) chain_res = chain_code(b);
        end
    end

    always_comb begin
        if (check_en && chain_res != E_NONE) code = chain_res;
        else if (!hdr_ok)                    code = E_HEADER;
        else                                 code = E_NONE;
    end
endmodule

// File: rtl/rsp_status_decode.sv
module rsp_status_decode
    import rsp_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_strobe,
    input  logic [RSP_W-1:0]  rsp_bytes,
    input  logic [5:0]        issued_cmd,
    input  logic              is_r6,
    input  logic [1:0]        upstream_err,
    output logic              out_valid,
    output logic [CODE_W-1:0] err_code,
    output logic [3:0]        card_state,
    output logic              rdy_data,
    output logic [31:0]       rca_arg
);
    typedef enum logic {ST_IDLE, ST_SHOW} dec_state_t;

    dec_state_t        state_q, state_d;
    logic [STAT_W-1:0] status_w;
    logic [7:0]        hdr_w;
    logic [31:0]       rca_w;
    err_code_t         chain_w;
    err_code_t         code_d;
    logic [3:0]        cstate_d;
    logic              rdy_d;
    logic [31:0]       rca_d;

    rsp_field_split u_split (
        .rsp       (rsp_bytes),
        .addr_mode (is_r6),
        .status    (status_w),
        .hdr_byte  (hdr_w),
        .rca_word  (rca_w)
    );

    rsp_err_chain u_chain (
        .status (status_w),
        .hdr_ok (hdr_w == {2'b00, issued_cmd}),
        .code   (chain_w)
    );

    // Upstream faults bypass decoding entirely
    always_comb begin
        if (upstream_err[0] || upstream_err[1]) begin
            code_d   = upstream_err[0] ? E_TIMEOUT : E_CRC;
            cstate_d = 4'h0;
            rdy_d    = 1'b0;
            rca_d    = 32'h0;
        end else begin
            code_d   = chain_w;
            cstate_d = status_w[12:9];
            rdy_d    = status_w[8];
            rca_d    = rca_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_strobe) state_d = ST_SHOW;
            ST_SHOW: if (!in_strobe) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_code   <= '0;
            card_state <= '0;
            rdy_data   <= 1'b0;
            rca_arg    <= '0;
        end else if (in_strobe) begin
            err_code   <= code_d;
            card_state <= cstate_d;
            rdy_data   <= rdy_d;
            rca_arg    <= rca_d;
        end
    end

    assign out_valid = (state_q == ST_SHOW);
endmodule

// File: rtl/rsp_status_decode_chk.sv
module rsp_status_decode_chk
    import rsp_dec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_strobe,
    input logic [RSP_W-1:0]  rsp_bytes,
    input logic [5:0]        issued_cmd,
    input logic              is_r6,
    input logic [1:0]        upstream_err,
    input logic              out_valid,
    input logic [CODE_W-1:0] err_code,
    input logic [3:0]        card_state,
    input logic              rdy_data,
    input logic [31:0]       rca_arg
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_strobe |=> !out_valid); // R1
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_strobe |=> $stable(err_code) && $stable(card_state) && $stable(rca_arg)); // R1
    AST_LOCK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && upstream_err == 2'b00 && !is_r6
         && rsp_bytes[39:8] == 32'h0200_0000
         && rsp_bytes[47:40] == {2'b00, issued_cmd}) |=> err_code == 5'd0); // R4
    AST_TIMEOUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && upstream_err[0]) |=> (err_code == 5'd1 && rca_arg == 32'h0)); // R8
    AST_RCA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rca_arg[15:0] == 16'h0); // R7
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> err_code <= 5'd18); // R3
endmodule

bind rsp_status_decode rsp_status_decode_chk u_chk (.*);

// File: tb/rsp_status_decode_test.sv
module rsp_status_decode_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_strobe = 1'b0;
    logic [47:0] rsp_bytes = '0;
    logic [5:0]  issued_cmd = '0;
    logic        is_r6 = 1'b0;
    logic [1:0]  upstream_err = '0;
    logic        out_valid;
    logic [4:0]  err_code;
    logic [3:0]  card_state;
    logic        rdy_data;
    logic [31:0] rca_arg;

    int n_run = 0;
    int n_fail = 0;

    rsp_status_decode uut (
        .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .rsp_bytes(rsp_bytes),
        .issued_cmd(issued_cmd), .is_r6(is_r6), .upstream_err(upstream_err),
        .out_valid(out_valid), .err_code(err_code), .card_state(card_state),
        .rdy_data(rdy_data), .rca_arg(rca_arg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input logic [7:0] hdr, input logic [31:0] st);
        return {hdr, st, 8'hA5};
    endfunction

    // Strobe one response, then sample on the following falling edge
    task automatic send(input logic [47:0] r, input logic [5:0] cmd,
                        input logic r6, input logic [1:0] up);
        @(negedge clk);
        rsp_bytes = r; issued_cmd = cmd; is_r6 = r6; upstream_err = up;
        in_strobe = 1'b1;
        @(negedge clk);
        in_strobe = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 valid", {31'b0, out_valid}, 32'h0);
        check("R9 code", {27'b0, err_code}, 32'h0);
        check("R9 state", {28'b0, card_state}, 32'h0);
        check("R9 rdy", {31'b0, rdy_data}, 32'h0);
        check("R9 rca", rca_arg, 32'h0);
    endtask

    task automatic t_clean();
        send(mk(8'd17, 32'h0000_0900), 6'd17, 1'b0, 2'b00);
        check("R1 valid pulse", {31'b0, out_valid}, 32'h1);
        check("R2 code", {27'b0, err_code}, 32'h0);
        check("R2 state", {28'b0, card_state}, 32'h4);
        check("R2 rdy", {31'b0, rdy_data}, 32'h1);
        check("R7 rca zero", rca_arg, 32'h0);
        @(negedge clk);
        check("R1 valid drops", {31'b0, out_valid}, 32'h0);
    endtask

    task automatic t_chain_single();
        int expc = 3;
        for (int b = 31; b >= 16; b--) begin
            if (b == 25) continue;
            send(mk(8'd18, 32'h1 << b), 6'd18, 1'b0, 2'b00);
            check($sformatf("R3 bit %0d", b), {27'b0, err_code}, expc);
            expc++;
        end
    endtask

    task automatic t_chain_multi();
        send(mk(8'd18, 32'h4002_0000), 6'd18, 1'b0, 2'b00);
        check("R3 bits 30+17", {27'b0, err_code}, 32'd4);
        send(mk(8'd18, 32'h0301_0000), 6'd18, 1'b0, 2'b00);
        check("R3 bits 25+24+16", {27'b0, err_code}, 32'd9);
    endtask

    task automatic t_lock();
        send(mk(8'd13, 32'h0200_0000), 6'd13, 1'b0, 2'b00);
        check("R4 lock only", {27'b0, err_code}, 32'd0);
        send(mk(8'd12, 32'h0200_0000), 6'd13, 1'b0, 2'b00);
        check("R4 lock with bad header", {27'b0, err_code}, 32'd18);
    endtask

    task automatic t_low_bits();
        send(mk(8'd7, 32'h0000_FFFF), 6'd7, 1'b0, 2'b00);
        check("R5 bits 15:0", {27'b0, err_code}, 32'd0);
        check("R5 state", {28'b0, card_state}, 32'hF);
        send(mk(8'h47, 32'h0000_E000), 6'd7, 1'b0, 2'b00);
        check("R5 masked bits bad header", {27'b0, err_code}, 32'd18);
    endtask

    task automatic t_header();
        send(mk(8'd9, 32'h0), 6'd10, 1'b0, 2'b00);
        check("R6 mismatch", {27'b0, err_code}, 32'd18);
        send(mk(8'd9, 32'h0040_0000), 6'd10, 1'b0, 2'b00);
        check("R6 status wins", {27'b0, err_code}, 32'd11);
    endtask

    task automatic t_addr_rsp();
        send(mk(8'd3, 32'hBEEF_0520), 6'd3, 1'b1, 2'b00);
        check("R7 rca", rca_arg, 32'hBEEF_0000);
        check("R7 no error", {27'b0, err_code}, 32'd0);
        check("R7 state", {28'b0, card_state}, 32'h2);
        check("R7 rdy", {31'b0, rdy_data}, 32'h1);
    endtask

    task automatic t_upstream();
        send(mk(8'd3, 32'hFFFF_FFFF), 6'd3, 1'b1, 2'b01);
        check("R8 timeout", {27'b0, err_code}, 32'd1);
        check("R8 rca zero", rca_arg, 32'h0);
        check("R8 state zero", {28'b0, card_state}, 32'h0);
        send(mk(8'd3, 32'h8000_0000), 6'd3, 1'b0, 2'b11);
        check("R8 timeout wins", {27'b0, err_code}, 32'd1);
        send(mk(8'd3, 32'h0000_0100), 6'd3, 1'b0, 2'b10);
        check("R8 crc", {27'b0, err_code}, 32'd2);
        check("R8 rdy zero", {31'b0, rdy_data}, 32'h0);
    endtask

    task automatic t_hold();
        send(mk(8'd3, 32'hBEEF_0520), 6'd3, 1'b1, 2'b00);
        @(negedge clk);
        rsp_bytes = mk(8'd1, 32'h8000_1E00); issued_cmd = 6'd2; is_r6 = 1'b0;
        @(negedge clk);
        check("R1 hold valid", {31'b0, out_valid}, 32'h0);
        check("R1 hold rca", rca_arg, 32'hBEEF_0000);
        check("R1 hold code", {27'b0, err_code}, 32'd0);
        check("R1 hold state", {28'b0, card_state}, 32'h2);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        rsp_bytes = mk(8'd5, 32'h0); issued_cmd = 6'd5; is_r6 = 1'b0; upstream_err = 2'b00;
        in_strobe = 1'b1;
        @(negedge clk);
        check("R1 first valid", {31'b0, out_valid}, 32'h1);
        check("R6 first code", {27'b0, err_code}, 32'd0);
        rsp_bytes = mk(8'd5, 32'h2000_0000);
        @(negedge clk);
        in_strobe = 1'b0;
        check("R1 second valid", {31'b0, out_valid}, 32'h1);
        check("R3 second code", {27'b0, err_code}, 32'd5);
        @(negedge clk);
        check("R1 valid ends", {31'b0, out_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_clean();
        t_chain_single();
        t_chain_multi();
        t_lock();
        t_low_bits();
        t_header();
        t_addr_rsp();
        t_upstream();
        t_hold();
        t_back_to_back();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule